// File: doc/BRIEF.md
# Monitor Channel Double-Look Receiver

This block is the receiving half of a byte-wide monitor-channel handshake carried in a time-division frame. Once per frame a strobe marks the slot. On that strobe the block samples the slot byte and the sender's active-low MX bit. It drives the active-low MR bit that the sender watches. A byte counts as received only when the same value has been seen in two frames in a row. A single corrupted or changing frame therefore never reaches the consumer.

Accepted bytes leave the block as a one-clock `byte_valid` pulse with the byte on `byte_data`. The block also recognises the end of a message and flags handshake errors. It can abort a reception on a local request by holding MR inactive for two frames. It has no link to any transmitter, so a transmitter on the same channel can run at the same time (full duplex). A downstream stage that cannot take a byte raises `out_busy`. The block then holds back both the byte and its acknowledge, and this stalls the sender.

Top module: `mon_dlr_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `mr_n` is 1 and `byte_valid`, `eom` and `abort` are 0.
- R2: With no message in progress, `mr_n` stays 1 (released). A frame with `mx_n` = 1 leaves the block idle.
- R3: A byte is accepted on the strobe at which `slot_data` equals the value sampled at the previous strobe, with `mx_n` = 0 at both. `byte_valid` is then 1 for exactly one clock after that strobe, and `byte_data` holds the accepted value.
- R4: When two successive samples differ, nothing is accepted and nothing is aborted. The newer sample becomes the reference, and a later identical sample is accepted.
- R5: Acceptance of the first byte of a message drives `mr_n` to 0 from the clock after that strobe.
- R6: Acceptance of each later byte drives `mr_n` to 1 for one frame and back to 0 at the next strobe. While the sender keeps `mx_n` at 0 after an acknowledge, no further byte is accepted.
- R7: After an acknowledged byte, `mx_n` = 1 at two successive strobes raises `eom` for one clock and releases `mr_n` to 1.
- R8: `mx_n` = 1 at a strobe while a byte is still waiting for its second identical sample is a handshake error. The block raises `abort` for one clock and holds `mr_n` at 1 for the next two strobes before it returns to idle.
- R9: `abort_req` = 1 at a strobe during a message raises `abort` and gives the same two-frame MR release as R8. When the block is idle, `abort_req` has no effect.
- R10: With `out_busy` = 1 at a strobe where a byte would be accepted, neither the byte nor its acknowledge is given. The byte is accepted at the first later strobe with `out_busy` = 0 and a matching sample.
- R11: Inputs are only looked at on `frame_stb`. Between strobes `mr_n` does not change, and `byte_valid`, `eom` and `abort` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-clock pulse marking the monitor slot of a frame |
| slot_data | input | DW | Byte present in the monitor slot |
| mx_n | input | 1 | Sender's MX bit, 0 = active |
| out_busy | input | 1 | Downstream cannot take a byte; acknowledge is withheld |
| abort_req | input | 1 | Local request to abort the reception in progress |
| mr_n | output | 1 | Receiver's MR bit, 0 = active |
| byte_data | output | DW | Most recently accepted byte |
| byte_valid | output | 1 | One-clock pulse when a byte is accepted |
| eom | output | 1 | One-clock pulse at end of message |
| abort | output | 1 | One-clock pulse when a reception is aborted |

## Verification
The bench sends bytes whose value changes between the first and second look. A design that trusted a single sample, or that aborted on a mismatch, would then show a spurious valid or abort. It also checks the difference between the first acknowledge (MR steps low) and later ones (a one-frame MR high pulse); swapping the two would show on `mr_n` in the affected frame. Further cases are a lone inactive MX frame against a double one, MX dropping before a byte is acknowledged, busy stalls and noise between strobes. Getting any of these wrong would produce a missed end of message, a missed or false abort, or a byte delivered while stalled.

// File: rtl/mon_dlr_pkg.sv
package mon_dlr_pkg;

    // Reception phase, advanced only on the frame strobe
    typedef enum logic [2:0] {
        PH_IDLE, // no message, MR released
        PH_LOOK, // waiting for a second identical sample
        PH_HOLD, // byte acknowledged, MR active
        PH_ACKP, // one-frame MR release acknowledging a later byte
        PH_GAP,  // sender dropped MX once: next byte or end of message
        PH_AB1,  // abort, first released frame
        PH_AB2   // abort, second released frame
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   first;
        logic   valid;
        logic   eom;
        logic   abort;
    } ctrl_s;

endpackage

// File: rtl/mon_dlr_look.sv
module mon_dlr_look #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          flush,
    input  logic [DW-1:0] din,
    output logic          match
);

    typedef struct packed {
        logic [DW-1:0] samp;
        logic          have;
    } look_s;

    look_s look_d, look_q;

    always_comb begin
        look_d = look_q;
        if (flush) begin
            look_d.have = 1'b0;
        end else if (load) begin
            look_d.samp = din;
            look_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) look_q <= '0;
        else        look_q <= look_d;
    end

    assign match = look_q.have && (din == look_q.samp);

endmodule

// File: rtl/mon_dlr_ctrl.sv
module mon_dlr_ctrl
    import mon_dlr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic mx_act,
    input  logic match,
    input  logic busy,
    input  logic abort_req,
    output logic load,
    output logic flush,
    output logic take,
    output logic valid,
    output logic eom,
    output logic abort,
    output logic mr_n
);

    ctrl_s c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        c_d.eom   = 1'b0;
        c_d.abort = 1'b0;
        load      = 1'b0;
        flush     = 1'b0;
        take      = 1'b0;
        if (stb) begin
            if (abort_req && (c_q.ph inside {PH_LOOK, PH_HOLD, PH_ACKP, PH_GAP})) begin
                c_d.ph    = PH_AB1;
                c_d.abort = 1'b1;
                flush     = 1'b1;
            end else begin
                unique case (c_q.ph)
                    PH_IDLE: begin
                        if (mx_act) begin
                            load      = 1'b1;
                            c_d.ph    = PH_LOOK;
                            c_d.first = 1'b1;
                        end
                    end
                    PH_LOOK: begin
                        if (!mx_act) begin
                            c_d.ph    = PH_AB1;
                            c_d.abort = 1'b1;
                            flush     = 1'b1;
                        end else if (match && !busy) begin
                            take      = 1'b1;
                            c_d.valid = 1'b1;
                            flush     = 1'b1;
                            c_d.ph    = c_q.first ? PH_HOLD : PH_ACKP;
                            c_d.first = 1'b0;
                        end else begin
                            load = 1'b1;
                        end
                    end
                    PH_HOLD: begin
                        if (!mx_act) c_d.ph = PH_GAP;
                    end
                    PH_ACKP: begin
                        c_d.ph = mx_act ? PH_HOLD : PH_GAP;
                    end
                    PH_GAP: begin
                        if (mx_act) begin
                            load   = 1'b1;
                            c_d.ph = PH_LOOK;
                        end else begin
                            c_d.eom = 1'b1;
                            c_d.ph  = PH_IDLE;
                        end
                    end
                    PH_AB1:  c_d.ph = PH_AB2;
                    PH_AB2:  c_d.ph = PH_IDLE;
                    default: c_d.ph = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{ph: PH_IDLE, default: 1'b0};
        else        c_q <= c_d;
    end

    always_comb begin
        unique case (c_q.ph)
            PH_HOLD, PH_GAP: mr_n = 1'b0;
            PH_LOOK:         mr_n = c_q.first;
            default:         mr_n = 1'b1;
        endcase
    end

    assign valid = c_q.valid;
    assign eom   = c_q.eom;
    assign abort = c_q.abort;

endmodule

// File: rtl/mon_dlr_rx.sv
module mon_dlr_rx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic [DW-1:0] slot_data,
    input  logic          mx_n,
    input  logic          out_busy,
    input  logic          abort_req,
    output logic          mr_n,
    output logic [DW-1:0] byte_data,
    output logic          byte_valid,
    output logic          eom,
    output logic          abort
);

    logic          load, flush, match, take;
    logic [DW-1:0] data_d, data_q;

    mon_dlr_look #(.DW(DW)) u_look (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .flush (flush),
        .din   (slot_data),
        .match (match)
    );

    mon_dlr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (frame_stb),
        .mx_act    (!mx_n),
        .match     (match),
        .busy      (out_busy),
        .abort_req (abort_req),
        .load      (load),
        .flush     (flush),
        .take      (take),
        .valid     (byte_valid),
        .eom       (eom),
        .abort     (abort),
        .mr_n      (mr_n)
    );

    always_comb begin
        data_d = data_q;
        if (take) data_d = slot_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign byte_data = data_q;

endmodule

// File: rtl/mon_dlr_rx_chk.sv
module mon_dlr_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_stb,
    input logic out_busy,
    input logic mr_n,
    input logic byte_valid,
    input logic eom,
    input logic abort
);

    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    p_eom_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eom |-> (mr_n && !abort && !byte_valid));

    p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> mr_n);

    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && out_busy) |=> !byte_valid);

    p_quiet_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(mr_n) && !byte_valid && !eom && !abort));

endmodule

bind mon_dlr_rx mon_dlr_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_stb  (frame_stb),
    .out_busy   (out_busy),
    .mr_n       (mr_n),
    .byte_valid (byte_valid),
    .eom        (eom),
    .abort      (abort)
);

// File: tb/mon_dlr_rx_test.sv
module mon_dlr_rx_test;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_stb = 1'b0;
    logic [DW-1:0] slot_data = '0;
    logic          mx_n = 1'b1;
    logic          out_busy = 1'b0;
    logic          abort_req = 1'b0;
    logic          mr_n;
    logic [DW-1:0] byte_data;
    logic          byte_valid, eom, abort;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    mon_dlr_rx #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .slot_data(slot_data),
        .mx_n(mx_n), .out_busy(out_busy), .abort_req(abort_req), .mr_n(mr_n),
        .byte_data(byte_data), .byte_valid(byte_valid), .eom(eom), .abort(abort)
    );

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    // step: 0 idle, 1 awaiting repeat, 2 acknowledged, 3 release pulse,
    //       4 one quiet MX frame seen, 5/6 abort frames
    int       step = 0;
    bit       first_byte = 0;
    int       ref_val[$];
    int       got_bytes[$];
    bit       e_valid = 0, e_eom = 0, e_abort = 0;
    int       e_data = 0;

    function automatic bit e_mr();
        if (step == 2 || step == 4) return 1'b0;
        if (step == 1) return first_byte;
        return 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step = 0; first_byte = 0; ref_val.delete();
            e_valid = 0; e_eom = 0; e_abort = 0; e_data = 0;
        end else begin
            e_valid = 0; e_eom = 0; e_abort = 0;
            if (frame_stb) begin
                if (abort_req && step >= 1 && step <= 4) begin
                    e_abort = 1; step = 5; ref_val.delete();
                end else if (step == 0) begin
                    if (!mx_n) begin ref_val.push_back(slot_data); step = 1; first_byte = 1; end
                end else if (step == 1) begin
                    if (mx_n) begin
                        e_abort = 1; step = 5; ref_val.delete();
                    end else if (ref_val.size() > 0 && ref_val[$] == int'(slot_data) && !out_busy) begin
                        e_valid = 1; e_data = slot_data; got_bytes.push_back(slot_data);
                        ref_val.delete();
                        step = first_byte ? 2 : 3;
                        first_byte = 0;
                    end else begin
                        ref_val.delete(); ref_val.push_back(slot_data);
                    end
                end else if (step == 2) begin
                    if (mx_n) step = 4;
                end else if (step == 3) begin
                    step = mx_n ? 4 : 2;
                end else if (step == 4) begin
                    if (!mx_n) begin ref_val.push_back(slot_data); step = 1; end
                    else begin e_eom = 1; step = 0; end
                end else if (step == 5) step = 6;
                else step = 0;
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 mr_n", mr_n, e_mr());
            check("R3 byte_valid", byte_valid, e_valid);
            check("R7 eom", eom, e_eom);
            check("R8 abort", abort, e_abort);
            if (byte_valid) begin
                if (got_bytes.size() > 0) check("R3 byte_data", byte_data, got_bytes.pop_front());
                else check("R3 byte_data unexpected", byte_data, -1);
            end
        end
    end

    // ---------------- stimulus ----------------
    bit noise = 1;

    task automatic frame(bit mx, int d, bit busy = 0, bit ab = 0);
        @(negedge clk);
        mx_n = mx; slot_data = d[DW-1:0]; out_busy = busy; abort_req = ab;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        if (noise) begin
            mx_n = $urandom; slot_data = $urandom; out_busy = $urandom; abort_req = $urandom;
        end
    endtask

    task automatic gap();
        @(negedge clk);
        if (noise) begin
            mx_n = $urandom; slot_data = $urandom; out_busy = $urandom; abort_req = $urandom;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset mr_n", mr_n, 1);
        check("R1 reset valid", byte_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset eom", eom, 0);
        check("R1 after reset abort", abort, 0);

        // R2: idle, MX inactive; abort_req ignored when idle (R9)
        frame(1, 8'h00); gap();
        frame(1, 8'h77, 0, 1);
        check("R2 idle mr_n", mr_n, 1);
        check("R9 idle abort_req ignored", abort, 0);
        gap();

        // R3/R5: first byte
        frame(0, 8'hA5);
        check("R3 single look no valid", byte_valid, 0);
        gap();
        frame(0, 8'hA5);
        check("R3 double look valid", byte_valid, 1);
        check("R3 data", byte_data, 8'hA5);
        check("R5 first ack mr_n", mr_n, 0);
        gap();
        frame(0, 8'hA5); // sender delays
        check("R6 no repeat accept", byte_valid, 0);
        gap();
        frame(1, 8'h00); gap();

        // R4/R6: second byte with mismatch first
        frame(0, 8'h3C); gap();
        frame(0, 8'h3D);
        check("R4 mismatch no valid", byte_valid, 0);
        check("R4 mismatch no abort", abort, 0);
        gap();
        frame(0, 8'h3D);
        check("R4 accept after mismatch", byte_data, 8'h3D);
        check("R6 release pulse", mr_n, 1);
        gap();
        frame(0, 8'h3D);
        check("R6 back active", mr_n, 0);
        gap();

        // R7: end of message
        frame(1, 8'h00);
        check("R7 single quiet no eom", eom, 0);
        gap();
        frame(1, 8'h00);
        check("R7 eom", eom, 1);
        check("R7 mr released", mr_n, 1);
        gap();

        // R8: MX drops before ack
        frame(0, 8'h11); gap();
        frame(1, 8'h11);
        check("R8 error abort", abort, 1);
        check("R8 mr released", mr_n, 1);
        gap();
        frame(1, 8'h00); check("R8 second release frame", mr_n, 1); gap();
        frame(1, 8'h00); gap();

        // R9: local abort during message
        frame(0, 8'h22); gap();
        frame(0, 8'h22); gap();
        frame(0, 8'h22, 0, 1);
        check("R9 local abort", abort, 1);
        check("R9 mr released", mr_n, 1);
        gap();
        frame(1, 8'h00); gap(); frame(1, 8'h00); gap();

        // R10: busy stall
        frame(0, 8'h44); gap();
        frame(0, 8'h44, 1);
        check("R10 busy no valid", byte_valid, 0);
        check("R10 busy no ack", mr_n, 1);
        gap();
        frame(0, 8'h44);
        check("R10 accept after busy", byte_valid, 1);
        check("R10 data", byte_data, 8'h44);
        gap();
        frame(1, 8'h00); gap(); frame(1, 8'h00); gap();

        // R11: noise between strobes, check quiet outputs
        repeat (5) begin
            gap();
            check("R11 quiet valid", byte_valid, 0);
        end

        // random traffic compared against the reference every clock
        for (int i = 0; i < 2000; i++) begin
            automatic bit mx = ($urandom % 4) == 0;
            automatic int d = $urandom % 4;
            frame(mx, d, ($urandom % 6) == 0, ($urandom % 40) == 0);
            repeat ($urandom % 3) gap();
        end

        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule